// File: doc/BRIEF.md
# Fault Supervisor with Sequenced Restart

This block watches three digital fault levels that arrive already filtered and with hysteresis applied: input undervoltage, input overvoltage and over-temperature. When a fault appears, it pulls one global power-good override high straight away. It keeps that override high for a minimum hold time. After a grace period, it withdraws run permission from all regulator channels. A voltage fault that clears inside the grace period does no more than hold power-good low for the minimum time. A fault that outlasts the grace period turns every channel off.

Once the faults have cleared, the block brings the channels back one at a time. The order is fixed, from the lowest channel to the highest, with a fixed gap between starts. After an over-temperature episode a long cool-down delay runs first. After a voltage episode the restart begins at once. Each channel's run output is the channel's external enable combined with the supervisor's permission. A channel whose enable is low still takes up its slot in the sequence but stays off. Every duration is counted in periods of a 1 µs tick strobe.

Top module: `fault_restart_supervisor`

## Requirements
- R1: Reset puts the block in normal running. `run_en` equals `ch_en` and `pg_force_low` is 0.
- R2: A fault flag that is seen while running sets `pg_force_low` on the next cycle. `pg_force_low` then stays high for at least HOLD_TICKS ticks, counted from that cycle.
- R3: A voltage fault that clears before GRACE_TICKS ticks leaves `run_en` unchanged. `pg_force_low` falls exactly HOLD_TICKS ticks after it rose.
- R4: A voltage fault that lasts GRACE_TICKS ticks sets every `run_en` bit to 0.
- R5: After a voltage-only shutdown, the restart sequence starts on the cycle after all flags read low, with no extra delay.
- R6: Over-temperature sets every `run_en` bit to 0 GRACE_TICKS ticks after it appears. This happens even if the flag has dropped again inside that window.
- R7: After an over-temperature shutdown, the first channel starts COOL_TICKS ticks after all flags read low.
- R8: The restart grants permission to bit 0 of `run_en` first. It then grants bits 1, 2 and 3 in turn, each GAP_TICKS ticks after the previous one.
- R9: `pg_force_low` falls only once the hold time has run out and the whole restart sequence has completed, whichever comes later.
- R10: A channel whose `ch_en` bit is 0 keeps its slot in the sequence, and its `run_en` bit stays 0.
- R11: A fault during a restart sequence aborts it. `run_en` goes to 0 on the next cycle, the hold time restarts, and a fresh sequence runs from bit 0 once the flags clear.
- R12: Over-temperature outranks the voltage faults. It can be present at the same time as a voltage fault, or arrive while a voltage fault is riding through. Either way the episode restarts its grace window from the over-temperature onset and ends with the cool-down delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe, once per microsecond |
| uv_in | input | 1 | Input undervoltage level |
| ov_in | input | 1 | Input overvoltage level |
| ot_in | input | 1 | Over-temperature level |
| ch_en | input | N_CH | External enable per channel |
| run_en | output | N_CH | Run command per channel (enable gated by supervisor permission) |
| pg_force_low | output | 1 | Global override forcing all power-good outputs low |

## Verification
The embedded properties assume the three fault flags are synchronous to `clk` and have already been cleaned of glitches. They also assume `tick` is a strobe that never stalls a timer for ever. The stimulus changes every input only on falling clock edges and holds `tick` high, so each timer advances once per cycle and the expected cycles follow directly from the tick counts. Each fault episode starts from plain running, after the previous hold time has expired. Episodes change `ch_en` only between them, so the combinational path from enable to run output is never sampled mid-change.

// File: rtl/fltsup_pkg.sv
package fltsup_pkg;

    typedef enum logic [2:0] {
        SUP_RUN  = 3'd0,
        SUP_RIDE = 3'd1,
        SUP_HEAT = 3'd2,
        SUP_OFF  = 3'd3,
        SUP_COOL = 3'd4,
        SUP_SEQ  = 3'd5
    } sup_state_e;

    typedef struct packed {
        logic under;
        logic over;
        logic heat;
    } fault_vec_t;

    function automatic logic any_fault(input fault_vec_t f);
        return f.under | f.over | f.heat;
    endfunction

    function automatic logic volt_fault(input fault_vec_t f);
        return f.under | f.over;
    endfunction

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/frs_phase_timer.sv
module frs_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && tick) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/frs_pg_hold.sv
module frs_pg_hold
    import fltsup_pkg::*;
#(
    parameter int HOLD_TICKS = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic trigger,
    output logic busy
);
    localparam int HW = cnt_width(HOLD_TICKS);

    logic [HW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (trigger) begin
            left <= HW'(HOLD_TICKS);
        end else if (tick && left != '0) begin
            left <= left - HW'(1);
        end
    end

    assign busy = (left != '0);

    // R2: without a new trigger the remaining hold never grows
    a_r2_hold_never_grows: assert property (@(posedge clk) disable iff (rst)
        !trigger |=> (left <= $past(left)));

    // R2: a trigger always leaves the hold running
    a_r2_hold_armed: assert property (@(posedge clk) disable iff (rst)
        trigger |=> busy);
endmodule

// File: rtl/frs_restart_seq.sv
module frs_restart_seq
    import fltsup_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int GAP_TICKS = 500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            start,
    input  logic            abort,
    output logic [N_CH-1:0] mask,
    output logic            busy
);
    localparam int GW = cnt_width(GAP_TICKS);
    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [GW-1:0] gap;
    logic [IW-1:0] idx;
    logic [IW-1:0] next_idx;

    assign next_idx = idx + IW'(1);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            mask <= '0;
            idx  <= '0;
            gap  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            mask <= N_CH'(1);
            idx  <= '0;
            gap  <= '0;
            busy <= (N_CH > 1);
        end else if (busy && tick) begin
            if (gap == GW'(GAP_TICKS - 1)) begin
                gap            <= '0;
                idx            <= next_idx;
                mask[next_idx] <= 1'b1;
                busy           <= (next_idx != IW'(N_CH - 1));
            end else begin
                gap <= gap + GW'(1);
            end
        end
    end

    // R8: while sequencing, granted slots stay granted and at most one is added per step
    a_r8_mask_grows: assert property (@(posedge clk) disable iff (rst)
        (busy && !abort && !start) |=>
            (((mask & $past(mask)) == $past(mask)) &&
             ($countones(mask) <= $countones($past(mask)) + 1)));

    // R11: an abort clears every grant
    a_r11_abort_clears: assert property (@(posedge clk) disable iff (rst)
        abort |=> (mask == '0 && !busy));
endmodule

// File: rtl/fault_restart_supervisor.sv
module fault_restart_supervisor
    import fltsup_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int GRACE_TICKS = 5000,
    parameter int HOLD_TICKS  = 50000,
    parameter int COOL_TICKS  = 2000000,
    parameter int GAP_TICKS   = 500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            uv_in,
    input  logic            ov_in,
    input  logic            ot_in,
    input  logic [N_CH-1:0] ch_en,
    output logic [N_CH-1:0] run_en,
    output logic            pg_force_low
);
    localparam int PHASE_MAX = (GRACE_TICKS > COOL_TICKS) ? GRACE_TICKS : COOL_TICKS;
    localparam int PW        = cnt_width(PHASE_MAX);

    fault_vec_t      flt;
    sup_state_e      st, nxt;
    logic [PW-1:0]   phase_cnt;
    logic            grace_hit, cool_hit;
    logic            anyf, volt;
    logic            hot_q;
    logic            hold_trig, hold_busy;
    logic            seq_start, seq_abort, seq_busy;
    logic [N_CH-1:0] seq_mask;
    logic [N_CH-1:0] permit;

    assign flt  = '{under: uv_in, over: ov_in, heat: ot_in};
    assign anyf = any_fault(flt);
    assign volt = volt_fault(flt);

    assign grace_hit = tick && (phase_cnt == PW'(GRACE_TICKS - 1));
    assign cool_hit  = tick && (phase_cnt == PW'(COOL_TICKS - 1));

    always_comb begin
        nxt = st;
        case (st)
            SUP_RUN:  if (flt.heat) nxt = SUP_HEAT;
                      else if (volt) nxt = SUP_RIDE;
            SUP_RIDE: if (flt.heat) nxt = SUP_HEAT;
                      else if (!volt) nxt = SUP_RUN;
                      else if (grace_hit) nxt = SUP_OFF;
            SUP_HEAT: if (grace_hit) nxt = SUP_OFF;
            SUP_OFF:  if (!anyf) nxt = hot_q ? SUP_COOL : SUP_SEQ;
            SUP_COOL: if (anyf) nxt = SUP_OFF;
                      else if (cool_hit) nxt = SUP_SEQ;
            SUP_SEQ:  if (anyf) nxt = SUP_OFF;
                      else if (!seq_busy) nxt = SUP_RUN;
            default:  nxt = SUP_OFF;
        endcase
    end

    assign seq_start = (nxt == SUP_SEQ) && (st != SUP_SEQ);
    assign seq_abort = (st == SUP_SEQ) && anyf;
    assign hold_trig = anyf && (st == SUP_RUN || st == SUP_COOL || st == SUP_SEQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SUP_RUN;
            hot_q <= 1'b0;
        end else begin
            st <= nxt;
            if (seq_start) begin
                hot_q <= 1'b0;
            end else if (flt.heat) begin
                hot_q <= 1'b1;
            end
        end
    end

    frs_phase_timer #(
        .W (PW)
    ) i_phase (
        .clk  (clk),
        .rst  (rst),
        .clr  (nxt != st),
        .en   (st == SUP_RIDE || st == SUP_HEAT || st == SUP_COOL),
        .tick (tick),
        .cnt  (phase_cnt)
    );

    frs_pg_hold #(
        .HOLD_TICKS (HOLD_TICKS)
    ) i_hold (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .trigger (hold_trig),
        .busy    (hold_busy)
    );

    frs_restart_seq #(
        .N_CH      (N_CH),
        .GAP_TICKS (GAP_TICKS)
    ) i_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .start (seq_start),
        .abort (seq_abort),
        .mask  (seq_mask),
        .busy  (seq_busy)
    );

    always_comb begin
        case (st)
            SUP_RUN, SUP_RIDE, SUP_HEAT: permit = '1;
            SUP_SEQ:                     permit = seq_mask;
            default:                     permit = '0;
        endcase
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_gate
        assign run_en[g] = ch_en[g] & permit[g];
    end

    assign pg_force_low = (st != SUP_RUN) || hold_busy;

    // R2: a fault seen while running forces power-good low next cycle
    a_r2_pg_low_on_fault: assert property (@(posedge clk) disable iff (rst)
        (anyf && st == SUP_RUN) |=> pg_force_low);

    // R4: a voltage fault reaching the end of its grace removes all permission
    a_r4_volt_shutdown: assert property (@(posedge clk) disable iff (rst)
        (st == SUP_RIDE && grace_hit && volt && !flt.heat) |=> (run_en == '0));

    // R6: over-temperature grace expiry removes all permission
    a_r6_heat_shutdown: assert property (@(posedge clk) disable iff (rst)
        (st == SUP_HEAT && grace_hit) |=> (run_en == '0));

    // R11: a fault during the restart sequence stops every channel
    a_r11_abort_drops: assert property (@(posedge clk) disable iff (rst)
        (st == SUP_SEQ && anyf) |=> (run_en == '0));

    // R9: power-good is never released while the sequence is still running
    a_r9_release_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(pg_force_low) |-> !seq_busy);
endmodule

// File: tb/test_fault_restart_supervisor.sv
module test_fault_restart_supervisor;
    localparam int NC = 4;
    localparam int GR = 6;
    localparam int HO = 30;
    localparam int CO = 25;
    localparam int GA = 5;

    logic          clk  = 1'b0;
    logic          rst  = 1'b1;
    logic          tick = 1'b1;
    logic          uv   = 1'b0;
    logic          ov   = 1'b0;
    logic          ot   = 1'b0;
    logic [NC-1:0] en   = 4'hF;
    wire  [NC-1:0] run;
    wire           pgl;

    int unsigned cyc    = 0;
    int unsigned checks = 0;
    int unsigned fails  = 0;
    bit          ended  = 1'b0;

    typedef struct {
        int unsigned at;
        logic [3:0]  run;
        logic        pg;
        string       req;
    } exp_t;

    exp_t q[$];

    fault_restart_supervisor #(
        .N_CH        (NC),
        .GRACE_TICKS (GR),
        .HOLD_TICKS  (HO),
        .COOL_TICKS  (CO),
        .GAP_TICKS   (GA)
    ) i_fault_restart_supervisor (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .uv_in        (uv),
        .ov_in        (ov),
        .ot_in        (ot),
        .ch_en        (en),
        .run_en       (run),
        .pg_force_low (pgl)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int unsigned at, input logic [3:0] r,
                             input logic p, input string req);
        exp_t e;
        e.at  = at;
        e.run = r;
        e.pg  = p;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic wait_to(input int unsigned at);
        while (cyc < at) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // monitor: pops expectations as their cycle arrives
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (e.at != cyc) begin
                    fails++;
                    $display("FAIL %s: sample for cycle %0d taken at %0d, expected cycle %0d",
                             e.req, e.at, cyc, e.at);
                end else if (run !== e.run || pgl !== e.pg) begin
                    fails++;
                    $display("FAIL %s: cycle %0d run_en=%b pg_force_low=%b, expected run_en=%b pg_force_low=%b",
                             e.req, cyc, run, pgl, e.run, e.pg);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    // driver
    initial begin
        int unsigned t0;
        repeat (3) @(negedge clk);

        // R1: reset state
        t0 = cyc;
        rst = 1'b0;
        en  = 4'b0101;
        expect_at(t0 + 1, 4'b0101, 1'b0, "R1");
        expect_at(t0 + 2, 4'b0101, 1'b0, "R1");
        wait_to(t0 + 3);
        en = 4'hF;
        wait_to(t0 + 6);

        // R3/R2: short undervoltage glitch rides through
        t0 = cyc;
        expect_at(t0 + 1,  4'hF, 1'b1, "R2");
        expect_at(t0 + 10, 4'hF, 1'b1, "R3");
        expect_at(t0 + 30, 4'hF, 1'b1, "R2");
        expect_at(t0 + 31, 4'hF, 1'b0, "R3");
        uv = 1'b1;
        wait_to(t0 + 3);
        uv = 1'b0;
        wait_to(t0 + 40);

        // R4/R5/R8/R9: overvoltage lasting past the grace, shorter than the hold
        t0 = cyc;
        expect_at(t0 + 6,  4'hF, 1'b1, "R4");
        expect_at(t0 + 7,  4'h0, 1'b1, "R4");
        expect_at(t0 + 15, 4'h0, 1'b1, "R5");
        expect_at(t0 + 16, 4'h1, 1'b1, "R5");
        expect_at(t0 + 20, 4'h1, 1'b1, "R8");
        expect_at(t0 + 21, 4'h3, 1'b1, "R8");
        expect_at(t0 + 26, 4'h7, 1'b1, "R8");
        expect_at(t0 + 31, 4'hF, 1'b1, "R9");
        expect_at(t0 + 32, 4'hF, 1'b0, "R9");
        ov = 1'b1;
        wait_to(t0 + 15);
        ov = 1'b0;
        wait_to(t0 + 45);

        // R10/R9: long undervoltage with two channels disabled
        t0 = cyc;
        en = 4'b1010;
        expect_at(t0 + 1,  4'b1010, 1'b1, "R2");
        expect_at(t0 + 7,  4'b0000, 1'b1, "R4");
        expect_at(t0 + 41, 4'b0000, 1'b1, "R10");
        expect_at(t0 + 46, 4'b0010, 1'b1, "R10");
        expect_at(t0 + 51, 4'b0010, 1'b1, "R10");
        expect_at(t0 + 56, 4'b1010, 1'b1, "R10");
        expect_at(t0 + 57, 4'b1010, 1'b0, "R9");
        uv = 1'b1;
        wait_to(t0 + 40);
        uv = 1'b0;
        wait_to(t0 + 60);
        en = 4'hF;
        wait_to(t0 + 65);

        // R6/R7: brief over-temperature still shuts down, then cool-down
        t0 = cyc;
        expect_at(t0 + 6,  4'hF, 1'b1, "R6");
        expect_at(t0 + 7,  4'h0, 1'b1, "R6");
        expect_at(t0 + 32, 4'h0, 1'b1, "R7");
        expect_at(t0 + 33, 4'h1, 1'b1, "R7");
        expect_at(t0 + 48, 4'hF, 1'b1, "R7");
        expect_at(t0 + 49, 4'hF, 1'b0, "R7");
        ot = 1'b1;
        wait_to(t0 + 3);
        ot = 1'b0;
        wait_to(t0 + 60);

        // R11: fault during the restart sequence
        t0 = cyc;
        expect_at(t0 + 11, 4'h1, 1'b1, "R5");
        expect_at(t0 + 17, 4'h3, 1'b1, "R8");
        expect_at(t0 + 18, 4'h0, 1'b1, "R11");
        expect_at(t0 + 21, 4'h1, 1'b1, "R11");
        expect_at(t0 + 26, 4'h3, 1'b1, "R11");
        expect_at(t0 + 31, 4'h7, 1'b1, "R11");
        expect_at(t0 + 36, 4'hF, 1'b1, "R11");
        expect_at(t0 + 37, 4'hF, 1'b1, "R11");
        expect_at(t0 + 47, 4'hF, 1'b1, "R11");
        expect_at(t0 + 48, 4'hF, 1'b0, "R2");
        uv = 1'b1;
        wait_to(t0 + 10);
        uv = 1'b0;
        wait_to(t0 + 17);
        uv = 1'b1;
        wait_to(t0 + 20);
        uv = 1'b0;
        wait_to(t0 + 55);

        // R12: undervoltage and over-temperature together
        t0 = cyc;
        expect_at(t0 + 7,  4'h0, 1'b1, "R12");
        expect_at(t0 + 21, 4'h0, 1'b1, "R12");
        expect_at(t0 + 35, 4'h0, 1'b1, "R12");
        expect_at(t0 + 36, 4'h1, 1'b1, "R12");
        expect_at(t0 + 51, 4'hF, 1'b1, "R12");
        expect_at(t0 + 52, 4'hF, 1'b0, "R12");
        uv = 1'b1;
        ot = 1'b1;
        wait_to(t0 + 10);
        uv = 1'b0;
        ot = 1'b0;
        wait_to(t0 + 60);

        // R12: over-temperature arriving while an overvoltage rides through
        t0 = cyc;
        expect_at(t0 + 8,  4'hF, 1'b1, "R12");
        expect_at(t0 + 9,  4'h0, 1'b1, "R12");
        expect_at(t0 + 37, 4'h0, 1'b1, "R12");
        expect_at(t0 + 38, 4'h1, 1'b1, "R12");
        expect_at(t0 + 54, 4'hF, 1'b0, "R9");
        ov = 1'b1;
        wait_to(t0 + 2);
        ot = 1'b1;
        wait_to(t0 + 12);
        ov = 1'b0;
        ot = 1'b0;
        wait_to(t0 + 60);

        while (q.size() > 0) @(negedge clk);
        finish_run();
    end
endmodule